// File: doc/BRIEF.md
# Core Clock Gear and Halt Gate

This block produces the processor core clock from the system clock as an enable pulse. A two-bit gear setting chooses one of four rates. Gear 0 gives an enable on every system cycle. Gears 1, 2 and 3 give a one-cycle enable every 2, 4 or 8 system cycles. Software sets the gear through a byte-wide control register on a small write port. The same byte can be read back on a separate output.

The block also gates the core clock in two low-power states.

- **Halt** stops only the core enable. The peripheral enable keeps running. Halt ends on a non-maskable interrupt, a maskable interrupt or an external interrupt.
- **Sleep** also freezes the divider and drops the peripheral enable. This models the removal of the system clock supply. Sleep ends only on an external interrupt.

Both states start at a core clock period boundary. On wake, the divider restarts from zero, so no core period is ever short or merged.

Top module: `core_clk_gear`

## Requirements
- R1: Gear code g (0 to 3) gives a core enable that is high for exactly one system cycle every 2^g system cycles (1, 2, 4 or 8).
- R2: After reset, the control byte reads 0x00, halted and sleeping are low, the peripheral enable is high, and the core enable is high on every cycle.
- R3: A write with wr_addr equal to REG_ADDR (default 0x5081) loads wr_data[1:0] into the gear field. A write to any other address leaves the field unchanged. Bits [7:2] of the control byte always read 0.
- R4: After a gear change from code a to code b, the interval that was running completes at the old length 2^a. Every later interval has the new length 2^b.
- R5: After a halt or sleep request strobe, exactly one more core enable occurs. The halted or sleeping flag rises on the cycle after that enable.
- R6: While halted, the core enable is low and the peripheral enable stays high.
- R7: Halt ends on nmi, irq or ext_irq. The first core enable comes 2^g cycles after the cycle in which the wake input was sampled.
- R8: While sleeping, the core enable and the peripheral enable are both low. The nmi and irq inputs have no effect.
- R9: Sleep ends only on ext_irq. The first core enable comes 2^g cycles after the cycle in which the wake input was sampled.
- R10: A reset during sleep clears sleeping and returns the gear field to 0, giving a full-rate core enable.
- R11: A halt strobe and a sleep strobe in the same cycle enter sleep, not halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 8 | Register write data |
| halt_req | input | 1 | Halt request strobe |
| sleep_req | input | 1 | Sleep request strobe |
| nmi | input | 1 | Non-maskable interrupt wake |
| irq | input | 1 | Maskable interrupt wake |
| ext_irq | input | 1 | External interrupt wake |
| core_en | output | 1 | Core clock enable pulse |
| periph_en | output | 1 | Peripheral clock enable |
| halted | output | 1 | Halt state flag |
| sleeping | output | 1 | Sleep state flag |
| ctrl_rdata | output | 8 | Control byte read-back |

## Verification
The bench builds the block with its default parameters: a two-bit gear field, a three-bit divider counter and the register address 0x5081. Under these defaults every gear code can be visited. The bench runs the interval checks over all four gears and the change-boundary checks over all sixteen old/new gear pairs. For each gear, it enters halt and wakes once from each of the three wake sources. For each gear, it also enters sleep, applies nmi and irq (which must be ignored), and then wakes with ext_irq.

// File: rtl/ccg_pkg.sv
// Shared types for the core clock gear block.
// Assumes a single system clock domain.
package ccg_pkg;
    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_HALT  = 2'd1,
        PS_SLEEP = 2'd2
    } pwr_state_t;
endpackage

// File: rtl/ccg_gear_reg.sv
// Control byte holding the gear field.
// Assumes writes are single-cycle strobes. Unused upper bits are not stored.
module ccg_gear_reg #(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int          GEAR_W   = 2,
    parameter logic [15:0] REG_ADDR = 16'h5081
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [GEAR_W-1:0] gear_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int PAD_W = DATA_W - GEAR_W;

    logic hit;
    logic [GEAR_W-1:0] gear_q;

    // Address decode for the control byte.
    assign hit = wr_en && (wr_addr == ADDR_W'(REG_ADDR));

    // Gear field storage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gear_q <= '0;
        else if (hit)
            gear_q <= wr_data[GEAR_W-1:0];
    end

    assign gear_o  = gear_q;
    assign rdata_o = {{PAD_W{1'b0}}, gear_q};

    // R3
    miss_keeps_gear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != ADDR_W'(REG_ADDR)) |=> $stable(gear_o));
endmodule

// File: rtl/ccg_divider.sv
// Gear divider.
// Counts system cycles up to 2^gear - 1 and flags the terminal count.
// The working gear is reloaded only at terminal count or during restart.
// Restart holds the counter at zero while the core is stopped.
module ccg_divider #(
    parameter int GEAR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic [GEAR_W-1:0] gear_i,
    output logic              tc_o
);
    localparam int CNT_W = (1 << GEAR_W) - 1;

    logic [GEAR_W-1:0] act_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  lim;

    // Limit mask: bit i is set when the working gear exceeds i.
    for (genvar i = 0; i < CNT_W; i++) begin : g_lim
        assign lim[i] = (act_q > GEAR_W'(i));
    end

    assign tc_o = !restart_i && (cnt_q == lim);

    // Counter and working gear: reload at terminal count, hold at zero on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= '0;
        end else if (restart_i || tc_o) begin
            cnt_q <= '0;
            act_q <= gear_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim);

    // R4
    gear_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_q) |-> ($past(tc_o) || $past(restart_i) || !$past(rst_n)));
endmodule

// File: rtl/ccg_power_fsm.sv
// Run / halt / sleep controller.
// Request strobes are held as pending until the next core period boundary.
// Sleep takes priority over halt. Halt wakes on any interrupt; sleep wakes
// only on the external interrupt.
module ccg_power_fsm
    import ccg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tc_i,
    input  logic       halt_req,
    input  logic       sleep_req,
    input  logic       nmi,
    input  logic       irq,
    input  logic       ext_irq,
    output pwr_state_t state_o
);
    pwr_state_t state_q;
    logic pend_halt_q;
    logic pend_sleep_q;

    // State transitions and pending-request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= PS_RUN;
            pend_halt_q  <= 1'b0;
            pend_sleep_q <= 1'b0;
        end else begin
            case (state_q)
                PS_RUN: begin
                    if (tc_i && pend_sleep_q) begin
                        state_q      <= PS_SLEEP;
                        pend_halt_q  <= 1'b0;
                        pend_sleep_q <= 1'b0;
                    end else if (tc_i && pend_halt_q) begin
                        state_q      <= PS_HALT;
                        pend_halt_q  <= 1'b0;
                        pend_sleep_q <= 1'b0;
                    end else begin
                        if (sleep_req) pend_sleep_q <= 1'b1;
                        if (halt_req)  pend_halt_q  <= 1'b1;
                    end
                end
                PS_HALT: begin
                    if (nmi || irq || ext_irq) state_q <= PS_RUN;
                end
                PS_SLEEP: begin
                    if (ext_irq) state_q <= PS_RUN;
                end
                default: state_q <= PS_RUN;
            endcase
        end
    end

    assign state_o = state_q;

    // R9
    sleep_exit_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == PS_SLEEP && state_q != PS_SLEEP) |-> ($past(ext_irq) || !$past(rst_n)));

    // R7
    halt_exit_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == PS_HALT && state_q != PS_HALT) |-> ($past(nmi || irq || ext_irq) || !$past(rst_n)));
endmodule

// File: rtl/core_clk_gear.sv
// Core clock gear and halt gate, top level.
// Emits a one-cycle core enable at the selected gear rate, gated in halt and
// sleep. Assumes a single system clock and a synchronous active-low reset.
module core_clk_gear
    import ccg_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int          GEAR_W   = 2,
    parameter logic [15:0] REG_ADDR = 16'h5081
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              halt_req,
    input  logic              sleep_req,
    input  logic              nmi,
    input  logic              irq,
    input  logic              ext_irq,
    output logic              core_en,
    output logic              periph_en,
    output logic              halted,
    output logic              sleeping,
    output logic [DATA_W-1:0] ctrl_rdata
);
    logic [GEAR_W-1:0] gear;
    logic              tc;
    pwr_state_t        state;

    ccg_gear_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GEAR_W(GEAR_W), .REG_ADDR(REG_ADDR)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .gear_o(gear), .rdata_o(ctrl_rdata)
    );

    ccg_divider #(.GEAR_W(GEAR_W)) u_div (
        .clk(clk), .rst_n(rst_n), .restart_i(state != PS_RUN),
        .gear_i(gear), .tc_o(tc)
    );

    ccg_power_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tc_i(tc), .halt_req(halt_req),
        .sleep_req(sleep_req), .nmi(nmi), .irq(irq), .ext_irq(ext_irq),
        .state_o(state)
    );

    // Output decode from the power state.
    assign core_en   = tc;
    assign halted    = (state == PS_HALT);
    assign sleeping  = (state == PS_SLEEP);
    assign periph_en = (state != PS_SLEEP);

    // R6
    no_core_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |-> (!halted && !sleeping));

    // R5
    halt_entry_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(core_en));

    // R5
    sleep_entry_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleeping) |-> $past(core_en));

    // R8
    sleep_gates_periph_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && !ext_irq) |=> (!periph_en && !core_en));
endmodule

// File: tb/core_clk_gear_tb.sv
module core_clk_gear_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic halt_req = 1'b0, sleep_req = 1'b0, nmi = 1'b0, irq = 1'b0, ext_irq = 1'b0;
    logic core_en, periph_en, halted, sleeping;
    logic [7:0] ctrl_rdata;
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    core_clk_gear u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .halt_req(halt_req), .sleep_req(sleep_req), .nmi(nmi), .irq(irq), .ext_irq(ext_irq),
        .core_en(core_en), .periph_en(periph_en), .halted(halted), .sleeping(sleeping),
        .ctrl_rdata(ctrl_rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; halt_req = 0; sleep_req = 0; nmi = 0; irq = 0; ext_irq = 0;
    endtask

    // Count negedges up to and including the next core enable.
    task automatic wait_pulse(output int n);
        n = 0;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            idle();
            n++;
            if (core_en) break;
        end
    endtask

    task automatic write_reg(input logic [15:0] a, input logic [7:0] d);
        int n;
        wr_en = 1; wr_addr = a; wr_data = d;
        wait_pulse(n);
    endtask

    // Settle on gear g, ending at the negedge of a pulse cycle.
    task automatic set_gear(input int g);
        int n;
        write_reg(16'h5081, 8'(g));
        wait_pulse(n);
        wait_pulse(n);
    endtask

    task automatic do_reset();
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    // Enter a stop state; count enables seen before the flag rises.
    task automatic enter_stop(input bit slp, input bit both, input string req);
        int pulses = 0;
        if (slp || both) sleep_req = 1;
        if (!slp || both) halt_req = 1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            idle();
            if (halted || sleeping) break;
            if (core_en) pulses++;
        end
        check(req, pulses, 1);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n;
        idle();
        do_reset();
        // R2 reset state
        check("R2 rdata", ctrl_rdata, 0);
        check("R2 halted", halted, 0);
        check("R2 sleeping", sleeping, 0);
        check("R2 periph_en", periph_en, 1);
        for (int k = 0; k < 4; k++) begin
            wait_pulse(n);
            check("R2 full rate", n, 1);
        end

        // R3 decode and read-back
        write_reg(16'h5081, 8'hFF);
        @(negedge clk);
        check("R3 upper bits zero", ctrl_rdata, 3);
        write_reg(16'h5080, 8'h00);
        @(negedge clk);
        check("R3 other address ignored", ctrl_rdata, 3);
        write_reg(16'h5081, 8'h02);
        @(negedge clk);
        check("R3 field load", ctrl_rdata, 2);

        // R1 interval per gear
        for (int g = 0; g < 4; g++) begin
            set_gear(g);
            for (int k = 0; k < 3; k++) begin
                wait_pulse(n);
                check("R1 interval", n, 1 << g);
            end
        end

        // R4 all gear pairs
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                set_gear(a);
                wr_en = 1; wr_addr = 16'h5081; wr_data = 8'(b);
                wait_pulse(n);
                check("R4 old interval", n, 1 << a);
                wait_pulse(n);
                check("R4 new interval", n, 1 << b);
                wait_pulse(n);
                check("R4 new interval", n, 1 << b);
            end
        end

        // R5 R6 R7 halt per gear and wake source
        for (int g = 0; g < 4; g++) begin
            for (int s = 0; s < 3; s++) begin
                int bad = 0;
                set_gear(g);
                enter_stop(1'b0, 1'b0, "R5 halt entry");
                check("R6 halted", halted, 1);
                for (int k = 0; k < 12; k++) begin
                    @(negedge clk);
                    if (core_en || !periph_en || !halted) bad++;
                end
                check("R6 gated while halted", bad, 0);
                if (s == 0) nmi = 1; else if (s == 1) irq = 1; else ext_irq = 1;
                wait_pulse(n);
                check("R7 first enable after wake", n, 1 << g);
                check("R7 halted cleared", halted, 0);
            end
        end

        // R5 R8 R9 sleep per gear
        for (int g = 0; g < 4; g++) begin
            int bad = 0;
            set_gear(g);
            enter_stop(1'b1, 1'b0, "R5 sleep entry");
            check("R8 sleeping", sleeping, 1);
            nmi = 1;
            @(negedge clk); idle();
            irq = 1;
            @(negedge clk); idle();
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (core_en || periph_en || !sleeping) bad++;
            end
            check("R8 nmi irq ignored in sleep", bad, 0);
            ext_irq = 1;
            wait_pulse(n);
            check("R9 first enable after wake", n, 1 << g);
            check("R9 sleeping cleared", sleeping, 0);
            check("R9 periph_en restored", periph_en, 1);
        end

        // R11 simultaneous requests
        set_gear(1);
        enter_stop(1'b0, 1'b1, "R11 entry");
        check("R11 sleep chosen", sleeping, 1);
        check("R11 not halted", halted, 0);
        ext_irq = 1;
        wait_pulse(n);

        // R10 reset during sleep
        set_gear(3);
        enter_stop(1'b1, 1'b0, "R10 entry");
        do_reset();
        check("R10 sleeping cleared", sleeping, 0);
        check("R10 gear cleared", ctrl_rdata, 0);
        wait_pulse(n);
        wait_pulse(n);
        check("R10 full rate", n, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule